// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer with Parallel Read Port

This block is the digital control side of a 16-bit sampling converter, modelled at the level of clock cycles. A falling edge on an active-low convert strobe starts a conversion. A busy flag then stays high for a fixed number of system clocks. One cycle before busy drops, the block captures the 16-bit word presented by a stub successive-approximation engine, so the result is ready the moment busy falls, with no pipeline delay.

The host reads the result over a parallel bus, gated by active-low chip select and read. The bus can be read as one 16-bit word. It can also be read as two bytes by toggling the byte-order input between accesses. A format input selects straight binary or two's complement, where two's complement is formed by inverting the most significant bit. When the converter is strapped for its serial port, the parallel pins are released entirely.

A separate abort input must be held for a minimum number of clocks. Once that width is reached it cancels any conversion in flight. A strobe that lands during a conversion is dropped, and the drop is recorded in a sticky flag.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy` and `strobe_dropped` are 0 and the held result is 0x0000.
- R2: When `busy` is low, a high-to-low change of `cnv_start_n` seen at a clock edge sets `busy` at that same edge.
- R3: `busy` stays high for exactly CONV_CYC clock cycles (default 125), unless an abort cuts it short.
- R4: The held result takes the value of `sar_result` at the edge one cycle before `busy` falls. It is therefore readable on `data_out` while `busy` is still high, and it does not change until the next capture.
- R5: With `straight_bin`=1, `data_out` shows the held result unchanged. With `straight_bin`=0, bit 15 is inverted and bits 14:0 are unchanged.
- R6: With `byte_swap`=0, result bits 7:0 appear on `data_out[7:0]` and bits 15:8 appear on `data_out[15:8]`. With `byte_swap`=1, the two bytes trade places. Any format inversion is applied before the swap.
- R7: `data_oe` is all ones only while `cs_n`=0, `rd_n`=0 and `ser_mode`=0 together. In every other case it is all zeros.
- R8: With `ser_mode`=1, every bus pin is released (`data_oe`=0, bits 1:0 included) whatever the state of `cs_n` and `rd_n`.
- R9: A strobe falling edge seen at an edge where `busy` is already high is ignored. The conversion length is unchanged, no new conversion follows, and `strobe_dropped` goes to 1 and stays there until `rst_n`.
- R10: When `conv_rst` has been high at RST_MIN_CYC consecutive edges (default 2), `busy` is cleared at the last of those edges and no capture takes place. A shorter pulse has no effect.
- R11: An abort that takes effect at the same edge as a capture, or at the same edge as a strobe, wins. The held result keeps its old value and no conversion starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_start_n | input | 1 | Active-low convert strobe, acted on at its falling edge |
| conv_rst | input | 1 | Active-high abort request with a minimum-width filter |
| sar_result | input | 16 | Conversion word from the stub SAR engine |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| ser_mode | input | 1 | 1: serial port selected, parallel bus released |
| byte_swap | input | 1 | 1: exchange the high and low result bytes on the bus |
| straight_bin | input | 1 | 1: straight binary, 0: two's complement (MSB inverted) |
| busy | output | 1 | Conversion in progress |
| data_out | output | 16 | Parallel bus data value |
| data_oe | output | 16 | Per-pin drive enable for the parallel bus |
| strobe_dropped | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The collision that matters is a convert strobe arriving at the same edge where the last busy cycle ends. The bench drops `cnv_start_n` right after the capture edge, so the next edge both ends the conversion and sees the strobe. It expects `busy` to fall on schedule, `strobe_dropped` to be set, and no second conversion afterwards. A second collision puts an abort on the capture edge itself. That case is judged by the shortened busy length and by the old result still being on the bus.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_t;

endpackage

// File: rtl/adc_strobe_det.sv
module adc_strobe_det #(
  parameter int RST_MIN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnv_start_n,
  input  logic conv_rst,
  output logic start_edge,
  output logic abort_act
);
  localparam int RCNT_W = $clog2(RST_MIN_CYC + 1);
  localparam logic [RCNT_W-1:0] RCNT_LAST = RCNT_W'(RST_MIN_CYC - 1);

  logic              cnv_q;
  logic [RCNT_W-1:0] rcnt_q, rcnt_d;

  // falling edge of the active-low strobe
  assign start_edge = cnv_q & ~cnv_start_n;

  // abort once the request has already been seen on RST_MIN_CYC-1 edges
  assign abort_act = conv_rst & (rcnt_q >= RCNT_LAST);

  always_comb begin
    rcnt_d = rcnt_q;
    if (!conv_rst) begin
      rcnt_d = '0;
    end else if (rcnt_q < RCNT_LAST) begin
      rcnt_d = rcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q  <= 1'b1;
      rcnt_q <= '0;
    end else begin
      cnv_q  <= cnv_start_n;
      rcnt_q <= rcnt_d;
    end
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_edge,
  input  logic              abort_act,
  input  logic [DATA_W-1:0] sar_result,
  output logic              busy,
  output logic              strobe_dropped,
  output logic [DATA_W-1:0] result_q
);
  localparam int CNT_W = $clog2(CONV_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cap_en;
  logic             drop_set;
  logic             drop_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cap_en   = 1'b0;
    drop_set = 1'b0;
    if (abort_act) begin
      st_d  = SEQ_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (start_edge) begin
            st_d  = SEQ_CONV;
            cnt_d = CNT_LOAD;
          end
        end
        SEQ_CONV: begin
          drop_set = start_edge;
          if (cnt_q == '0) begin
            st_d = SEQ_IDLE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
          if (cnt_q == CNT_CAP) begin
            cap_en = 1'b1;
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (cap_en) begin
      result_q <= sar_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
    end else if (drop_set) begin
      drop_q <= 1'b1;
    end
  end

  assign busy           = (st_q == SEQ_CONV);
  assign strobe_dropped = drop_q;

endmodule

// File: rtl/adc_par_port.sv
module adc_par_port #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] result_q,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              ser_mode,
  input  logic              byte_swap,
  input  logic              straight_bin,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] data_oe
);
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] coded;
  logic              bus_en;

  // two's complement view: flip the top bit only
  always_comb begin
    coded = result_q;
    if (!straight_bin) begin
      coded[DATA_W-1] = ~result_q[DATA_W-1];
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign data_out[b*8 +: 8] = byte_swap ? coded[(BYTES-1-b)*8 +: 8]
                                          : coded[b*8 +: 8];
  end

  assign bus_en  = ~ser_mode & ~cs_n & ~rd_n;
  assign data_oe = {DATA_W{bus_en}};

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYC    = 125,
  parameter int RST_MIN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_start_n,
  input  logic              conv_rst,
  input  logic [DATA_W-1:0] sar_result,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              ser_mode,
  input  logic              byte_swap,
  input  logic              straight_bin,
  output logic              busy,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] data_oe,
  output logic              strobe_dropped
);
  logic              start_edge;
  logic              abort_act;
  logic [DATA_W-1:0] result_q;

  adc_strobe_det #(.RST_MIN_CYC(RST_MIN_CYC)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnv_start_n(cnv_start_n),
    .conv_rst   (conv_rst),
    .start_edge (start_edge),
    .abort_act  (abort_act)
  );

  adc_conv_timer #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_edge    (start_edge),
    .abort_act     (abort_act),
    .sar_result    (sar_result),
    .busy          (busy),
    .strobe_dropped(strobe_dropped),
    .result_q      (result_q)
  );

  adc_par_port #(.DATA_W(DATA_W)) u_port (
    .result_q    (result_q),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .ser_mode    (ser_mode),
    .byte_swap   (byte_swap),
    .straight_bin(straight_bin),
    .data_out    (data_out),
    .data_oe     (data_oe)
  );

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 125
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start_edge,
  input logic              abort_act,
  input logic              strobe_dropped,
  input logic              ser_mode,
  input logic [DATA_W-1:0] data_oe,
  input logic [DATA_W-1:0] result_q
);
  localparam int BCNT_W = $clog2(CONV_CYC + 2);

  logic [BCNT_W-1:0] bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else if (busy) begin
      bcnt_q <= bcnt_q + 1'b1;
    end else begin
      bcnt_q <= '0;
    end
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_edge && !busy && !abort_act) |=> busy);

  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(abort_act)) |-> (bcnt_q == BCNT_W'(CONV_CYC)));

  a_r4_result_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $stable(result_q));

  a_r8_serial_release: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode |-> (data_oe == '0));

  a_r9_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start_edge && busy && !abort_act) |=> strobe_dropped);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_dropped |=> strobe_dropped);

  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_act |=> !busy);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .start_edge    (start_edge),
  .abort_act     (abort_act),
  .strobe_dropped(strobe_dropped),
  .ser_mode      (ser_mode),
  .data_oe       (data_oe),
  .result_q      (result_q)
);

// File: tb/adc_conv_seq_bench.sv
`timescale 1ns/1ps
module adc_conv_seq_bench;
  localparam int  CONV = 125;
  localparam real TCLK = 5.0;

  logic        clk = 1'b0;
  logic        rst_n, cnv_start_n, conv_rst;
  logic [15:0] sar_result;
  logic        cs_n, rd_n, ser_mode, byte_swap, straight_bin;
  logic        busy, strobe_dropped;
  logic [15:0] data_out, data_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(TCLK/2) clk = ~clk;

  adc_conv_seq u_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .cnv_start_n(cnv_start_n), .conv_rst(conv_rst),
    .sar_result(sar_result), .cs_n(cs_n), .rd_n(rd_n), .ser_mode(ser_mode),
    .byte_swap(byte_swap), .straight_bin(straight_bin), .busy(busy),
    .data_out(data_out), .data_oe(data_oe), .strobe_dropped(strobe_dropped)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic read_mode();
    cs_n = 0; rd_n = 0; ser_mode = 0; byte_swap = 0; straight_bin = 1;
  endtask

  // runs one conversion; returns the number of busy-high samples
  task automatic run_conv(input logic [15:0] val, input int glitch_at,
                          input int abort_at, input int abort_len, output int len);
    int n;
    cnv_start_n = 0;
    step();
    chk("R2 busy after strobe", busy, 1);
    cnv_start_n = 1;
    n = 1;
    forever begin
      if (n == CONV - 1) sar_result = val;
      if (n == CONV) begin
        if (abort_at < 0) chk("R4 data ready before busy falls", data_out, val);
        sar_result = ~val;
      end
      if (n == glitch_at)     cnv_start_n = 0;
      if (n == glitch_at + 1) cnv_start_n = 1;
      if (n == abort_at)             conv_rst = 1;
      if (n == abort_at + abort_len) conv_rst = 0;
      step();
      if (!busy) break;
      n++;
    end
    conv_rst = 0;
    len = n;
  endtask

  task automatic t_reset();
    rst_n = 0; cnv_start_n = 1; conv_rst = 0; sar_result = '0;
    read_mode();
    repeat (3) step();
    chk("R1 busy in reset", busy, 0);
    rst_n = 1;
    step();
    chk("R1 busy after reset", busy, 0);
    chk("R1 flag after reset", strobe_dropped, 0);
    chk("R1 result after reset", data_out, 16'h0000);
  endtask

  task automatic t_basic();
    int len;
    run_conv(16'h8123, -10, -10, 0, len);
    chk("R3 busy length", len, CONV);
    chk("R4 captured value", data_out, 16'h8123);
    chk("R9 no drop on clean run", strobe_dropped, 0);
    run_conv(16'h3c5a, -10, -10, 0, len);
    chk("R3 second length", len, CONV);
    chk("R4 second value", data_out, 16'h3c5a);
  endtask

  task automatic t_format();
    sar_result = 16'h0000;
    run_conv_quiet(16'h8123);
    straight_bin = 0; #1;
    chk("R5 twos complement", data_out, 16'h0123);
    straight_bin = 1; byte_swap = 1; #1;
    chk("R6 swapped bytes", data_out, 16'h2381);
    straight_bin = 0; #1;
    chk("R6 R5 swap after invert", data_out, 16'h2301);
    byte_swap = 0; straight_bin = 1; #1;
    chk("R6 normal order", data_out, 16'h8123);
  endtask

  task automatic run_conv_quiet(input logic [15:0] val);
    int len;
    run_conv(val, -10, -10, 0, len);
  endtask

  task automatic t_bus();
    chk("R7 bus driven on read", data_oe, 16'hffff);
    cs_n = 1; #1;
    chk("R7 released without select", data_oe, 16'h0000);
    cs_n = 0; rd_n = 1; #1;
    chk("R7 released without read", data_oe, 16'h0000);
    rd_n = 0; ser_mode = 1; #1;
    chk("R8 serial mode releases all pins", data_oe, 16'h0000);
    chk("R8 low pins released", data_oe[1:0], 2'b00);
    ser_mode = 0; #1;
  endtask

  task automatic t_drop();
    int len;
    run_conv(16'h1111, 10, -10, 0, len);
    chk("R9 length unchanged by strobe", len, CONV);
    chk("R9 flag set", strobe_dropped, 1);
    run_conv(16'h2222, -10, -10, 0, len);
    chk("R9 flag sticky", strobe_dropped, 1);
    // strobe lands on the edge that ends the conversion
    run_conv(16'h4444, CONV, -10, 0, len);
    chk("R9 collision length", len, CONV);
    chk("R4 collision value", data_out, 16'h4444);
    repeat (3) step();
    chk("R9 no conversion after collision", busy, 0);
    cnv_start_n = 1;
    step();
    t_reset();
    chk("R9 flag cleared by reset", strobe_dropped, 0);
  endtask

  task automatic t_abort();
    int len;
    run_conv(16'h5555, -10, -10, 0, len);
    run_conv(16'h6666, -10, 20, 2, len);
    chk("R10 abort shortens busy", len, 21);
    chk("R10 no capture on abort", data_out, 16'h5555);
    run_conv(16'h7777, -10, 30, 1, len);
    chk("R10 short pulse ignored", len, CONV);
    chk("R10 short pulse keeps capture", data_out, 16'h7777);
    run_conv(16'h9999, -10, CONV - 2, 2, len);
    chk("R11 abort on capture edge length", len, CONV - 1);
    chk("R11 abort beats capture", data_out, 16'h7777);
    step();
    conv_rst = 1;
    step();
    cnv_start_n = 0;
    step();
    chk("R11 abort beats strobe", busy, 0);
    conv_rst = 0; cnv_start_n = 1;
    step();
    chk("R11 stays idle", busy, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_format();
    t_bus();
    t_drop();
    t_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TCLK * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule